// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This block brings three supply rails up one after another and takes them down in the opposite order. The highest-voltage rail (driven through a switch gate enable) comes up first, then the middle regulator, then the lowest regulator. Each step waits a programmable number of clock cycles. Power-up steps wait on the power-on request and on the good flag of the rail enabled just before. Power-down steps wait for the rail just released to fall below its threshold before the next rail up is released.

All inputs are asynchronous to the controller clock and pass through two-flop synchronizers. The sequencer state is a single level: the count of enabled rails. The request level picks the direction of travel. If the request changes mid-sequence, the controller reverses from the level it has reached. It does not restart from either end.

Top module: `rail_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all three enables and the all-good status; the first output edge after reset sampled high shows them low.
- R2: With all enables off, the top rail enable (bit 0) rises exactly DELAY_CYC+2 clock edges after the request input goes high, counting the two synchronizer edges.
- R3: The middle rail enable (bit 1) rises DELAY_CYC+2 edges after good flag bit 0 goes high while the request is high, and never while that flag stays low.
- R4: The low rail enable (bit 2) rises DELAY_CYC+2 edges after good flag bit 1 goes high while the request is high, and never while that flag stays low.
- R5: With all three enabled, bit 2 drops DELAY_CYC+2 edges after the request goes low, while bits 0 and 1 stay high.
- R6: With the request low, bit 1 drops DELAY_CYC+2 edges after good flag bit 2 goes low, and never while that flag stays high.
- R7: With the request low, bit 0 drops DELAY_CYC+2 edges after good flag bit 1 goes low, and never while that flag stays high.
- R8: The enables always form a thermometer code: bit 2 set implies bit 1 set, and bit 1 set implies bit 0 set.
- R9: A request rising during power-down resumes power-up from the current level. Rails still enabled are not dropped, and the next rail is enabled DELAY_CYC+2 edges after the rise.
- R10: A request falling during power-up starts power-down from the lowest enabled rail. Each later release follows the R6/R7 good-flag rule.
- R11: The all-good output is high exactly when all three enables are set and all three synchronized good flags are high. It lags the good inputs by two edges.
- R12: A step happens only after its condition has held for DELAY_CYC consecutive cycles (DELAY_CYC at least 2). A shorter pulse on the request does not enable anything, and two enable changes are never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power-on request, asynchronous |
| rail_good | input | 3 | Per-rail above-threshold flags, bit 0 = top rail, asynchronous |
| rail_en | output | 3 | Rail enables: bit 0 switch gate, bits 1 and 2 regulator enables |
| all_good | output | 1 | All rails enabled and above threshold |

## Verification
A corrupted level register shows up at once as a non-thermometer enable pattern, or as an enable change with no matching request or flag condition one cycle before it. A timer that counts wrong moves an enable edge away from the DELAY_CYC+2 point. The bench samples each transition one edge early and at the exact edge, so an offset of a single cycle is caught. A reversed-direction fault shows within one step period as an enable moving the wrong way after a request change.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int unsigned N_RAILS = 3;
    localparam int unsigned LVL_W   = $clog2(N_RAILS + 1);

    typedef logic [LVL_W-1:0]   level_t;
    typedef logic [N_RAILS-1:0] rail_vec_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_t;

    typedef struct packed {
        logic      req;
        rail_vec_t good;
    } seq_obs_t;

    // Level n means rails 0..n-1 are enabled (thermometer code).
    function automatic rail_vec_t level_to_en(level_t lv);
        rail_vec_t v;
        for (int i = 0; i < N_RAILS; i++) begin
            v[i] = (lv > level_t'(i));
        end
        return v;
    endfunction

    // Direction the sequencer wants to move from level lv.
    function automatic dir_t next_dir(seq_obs_t o, level_t lv);
        dir_t d;
        d = DIR_HOLD;
        if (o.req) begin
            if (lv < level_t'(N_RAILS)) begin
                if (lv == '0)
                    d = DIR_UP;
                else if (o.good[lv - 1'b1])
                    d = DIR_UP;
            end
        end else begin
            if (lv != '0) begin
                if (lv == level_t'(N_RAILS))
                    d = DIR_DOWN;
                else if (!o.good[lv])
                    d = DIR_DOWN;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rsq_step_timer.sv
module rsq_step_timer
    import rsq_pkg::*;
#(
    parameter int unsigned DELAY = 8
) (
    input  logic clk,
    input  logic rst,
    input  dir_t dir,
    output logic fire
);
    localparam int unsigned CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_eff;
    dir_t          last_dir;

    // A change of direction restarts the count in the same cycle.
    assign cnt_eff = (dir == last_dir) ? cnt : '0;
    assign fire    = (dir != DIR_HOLD) && (cnt_eff == CW'(DELAY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            last_dir <= DIR_HOLD;
        end else begin
            last_dir <= dir;
            if (dir == DIR_HOLD || fire)
                cnt <= '0;
            else
                cnt <= cnt_eff + 1'b1;
        end
    end
endmodule

// File: rtl/rsq_level.sv
module rsq_level
    import rsq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dir_t   dir,
    input  logic   fire,
    output level_t level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (fire) begin
            if (dir == DIR_UP)
                level <= level + 1'b1;
            else if (dir == DIR_DOWN)
                level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 25_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_req,
    input  logic [N_RAILS-1:0]  rail_good,
    output logic [N_RAILS-1:0]  rail_en,
    output logic                all_good
);
    logic      req_s;
    rail_vec_t good_s;
    seq_obs_t  obs;
    level_t    level;
    dir_t      dir;
    logic      fire;

    rsq_sync #(.W(N_RAILS + 1), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwr_req, rail_good}),
        .q   ({req_s, good_s})
    );

    assign obs = {req_s, good_s};
    assign dir = next_dir(obs, level);

    rsq_step_timer #(.DELAY(DELAY_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .dir  (dir),
        .fire (fire)
    );

    rsq_level u_level (
        .clk   (clk),
        .rst   (rst),
        .dir   (dir),
        .fire  (fire),
        .level (level)
    );

    assign rail_en  = level_to_en(level);
    assign all_good = (level == level_t'(N_RAILS)) && (&good_s);
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_s,
    input logic [2:0] good_s,
    input logic [2:0] rail_en,
    input logic       all_good
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rail_en == 3'b000 && !all_good));

    a_r8_thermometer: assert property (@(posedge clk) disable iff (rst)
        (!rail_en[2] || rail_en[1]) && (!rail_en[1] || rail_en[0]));

    a_r2_top_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
        ($rose(rail_en[0]) && !$past(rst)) |-> $past(req_s));

    a_r3_mid_rise_needs_good0: assert property (@(posedge clk) disable iff (rst)
        ($rose(rail_en[1]) && !$past(rst)) |-> $past(req_s && good_s[0]));

    a_r4_low_rise_needs_good1: assert property (@(posedge clk) disable iff (rst)
        ($rose(rail_en[2]) && !$past(rst)) |-> $past(req_s && good_s[1]));

    a_r5_low_fall_needs_noreq: assert property (@(posedge clk) disable iff (rst)
        ($fell(rail_en[2]) && !$past(rst)) |-> $past(!req_s));

    a_r6_mid_fall_needs_low_gone: assert property (@(posedge clk) disable iff (rst)
        ($fell(rail_en[1]) && !$past(rst)) |-> $past(!req_s && !good_s[2]));

    a_r7_top_fall_needs_mid_gone: assert property (@(posedge clk) disable iff (rst)
        ($fell(rail_en[0]) && !$past(rst)) |-> $past(!req_s && !good_s[1]));

    a_r11_status_implies_all_on: assert property (@(posedge clk) disable iff (rst)
        all_good |-> (rail_en == 3'b111 && good_s == 3'b111));

    a_r12_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        ((rail_en != $past(rail_en)) && !$past(rst)) |=> $stable(rail_en));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_s    (req_s),
    .good_s   (good_s),
    .rail_en  (rail_en),
    .all_good (all_good)
);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
    localparam int unsigned DLY = 4;   // step delay; edge latency = DLY + 2
    localparam int NV = 18;

    // {req, good[2:0], wait edges[7:0], exp en[2:0], exp ok, req id[3:0]}
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b1, 3'b000, 8'd5,  3'b000, 1'b0, 4'd2},   // R2 not early
        {1'b1, 3'b000, 8'd1,  3'b001, 1'b0, 4'd2},   // R2 exact edge
        {1'b1, 3'b000, 8'd20, 3'b001, 1'b0, 4'd3},   // R3 waits for good0
        {1'b1, 3'b001, 8'd5,  3'b001, 1'b0, 4'd3},   // R3 not early
        {1'b1, 3'b001, 8'd1,  3'b011, 1'b0, 4'd3},   // R3 exact
        {1'b1, 3'b001, 8'd20, 3'b011, 1'b0, 4'd4},   // R4 waits for good1
        {1'b1, 3'b011, 8'd5,  3'b011, 1'b0, 4'd4},   // R4 not early
        {1'b1, 3'b011, 8'd1,  3'b111, 1'b0, 4'd4},   // R4 exact
        {1'b1, 3'b111, 8'd1,  3'b111, 1'b0, 4'd11},  // R11 sync lag
        {1'b1, 3'b111, 8'd1,  3'b111, 1'b1, 4'd11},  // R11 status up
        {1'b0, 3'b111, 8'd5,  3'b111, 1'b1, 4'd5},   // R5 not early
        {1'b0, 3'b111, 8'd1,  3'b011, 1'b0, 4'd5},   // R5 low rail off, R11 drop
        {1'b0, 3'b111, 8'd20, 3'b011, 1'b0, 4'd6},   // R6 holds while good2
        {1'b0, 3'b011, 8'd5,  3'b011, 1'b0, 4'd6},   // R6 not early
        {1'b0, 3'b011, 8'd1,  3'b001, 1'b0, 4'd6},   // R6 exact
        {1'b0, 3'b001, 8'd5,  3'b001, 1'b0, 4'd7},   // R7 not early
        {1'b0, 3'b001, 8'd1,  3'b000, 1'b0, 4'd7},   // R7 exact
        {1'b0, 3'b000, 8'd10, 3'b000, 1'b0, 4'd7}    // R7 stays off
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_req;
    logic [2:0] rail_good;
    logic [2:0] rail_en;
    logic       all_good;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    rail_seq_ctrl #(.DELAY_CYC(DLY)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pwr_req   (pwr_req),
        .rail_good (rail_good),
        .rail_en   (rail_en),
        .all_good  (all_good)
    );

    task automatic chk(input logic [2:0] een, input logic eok, input int rid);
        checks++;
        if (rail_en !== een || all_good !== eok) begin
            errors++;
            $display("FAIL R%0d: rail_en=%b all_good=%b expected rail_en=%b all_good=%b",
                     rid, rail_en, all_good, een, eok);
        end
    endtask

    task automatic step(input logic rq, input logic [2:0] gd, input int n);
        pwr_req   = rq;
        rail_good = gd;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pwr_req = 1'b0; rail_good = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(3'b000, 1'b0, 1);                       // R1 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19], VEC[i][18:16], int'(VEC[i][15:8]));
            chk(VEC[i][7:5], VEC[i][4], int'(VEC[i][3:0]));
        end

        // R12: request pulse shorter than the step delay
        step(1'b1, 3'b000, 3);
        step(1'b0, 3'b000, 20);
        chk(3'b000, 1'b0, 12);
        step(1'b1, 3'b000, DLY + 1);
        chk(3'b000, 1'b0, 12);
        step(1'b1, 3'b000, 1);
        chk(3'b001, 1'b0, 12);

        // R10: request drops at level two, down from the lowest enabled rail
        step(1'b1, 3'b001, DLY + 2);
        chk(3'b011, 1'b0, 10);
        step(1'b0, 3'b001, DLY + 1);
        chk(3'b011, 1'b0, 10);
        step(1'b0, 3'b001, 1);
        chk(3'b001, 1'b0, 10);
        step(1'b0, 3'b001, DLY + 2);
        chk(3'b000, 1'b0, 10);

        // R9: climb, start power-down, then raise request again
        step(1'b1, 3'b011, 3 * (DLY + 2));
        chk(3'b111, 1'b0, 9);
        step(1'b0, 3'b011, DLY + 2);
        chk(3'b011, 1'b0, 9);
        step(1'b1, 3'b011, DLY + 1);
        chk(3'b011, 1'b0, 9);
        step(1'b1, 3'b011, 1);
        chk(3'b111, 1'b0, 9);

        // R1: reset in the middle of operation
        rail_good = 3'b111;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(3'b000, 1'b0, 1);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule